// File: doc/BRIEF.md
# Standby Wake-Up Sequencing Controller

This controller puts a small processor subsystem into a clock-stopped standby state and brings it back out. Software arms the standby-enable bit and issues a sleep strobe. The controller then gates the chip clock and drops the oscillator-run request. While it waits, it watches two wake pins: a non-maskable wake pin with a one-bit edge select, and an interrupt pin with a two-bit edge mode. Both pins are synchronized onto the always-on clock.

A qualifying edge does not hand the clock back at once. The edge only raises the oscillator-run request. A stabilization counter, clocked from the always-on clock, must then reach its overflow before the chip clock is re-enabled. On that overflow the controller leaves standby and pulses a wake-exception request for one cycle, tagged with the source that caused the wake. The period select and both edge settings are captured when standby is entered, so software can enter on one edge and wake on the opposite one.

The state machine has four states. RUN: clock and oscillator on. STANDBY: both off, with the wake detectors armed. STABILIZE: oscillator on, clock still gated, counter running. WAKE: one cycle in which the clock is on and the exception request is pulsed. The transitions are:
- RUN to STANDBY, on sleep with enable set.
- STANDBY to STABILIZE, on a qualifying wake edge.
- STABILIZE to WAKE, on counter overflow.
- WAKE to RUN, unconditionally.

Top module: `stby_wake_ctrl`

## Requirements
- R1: While reset is applied and on leaving it, the controller is in RUN: `cpu_clk_en`=1, `osc_run`=1, `wake_req`=0.
- R2: A `sleep_req` sampled in RUN with `stby_en`=1 moves to STANDBY on that edge, so `cpu_clk_en`=0 and `osc_run`=0 from the next cycle.
- R3: A `sleep_req` sampled with `stby_en`=0 is ignored; the clock stays enabled.
- R4: `nmi_rise`, captured at entry, selects the wake edge of `nmi_pin`: 0 = falling, 1 = rising. The opposite edge does not wake.
- R5: `irq_mode`, captured at entry, uses 2'b01 = falling, 2'b10 = rising, 2'b11 = both. In standby, both-mode wakes on a falling edge only, and the edge opposite to the mode does not wake.
- R6: `irq_mode`=2'b00 (level) never wakes from standby, even with `irq_pin` held low.
- R7: A pin that already sits at its post-edge level when standby is entered does not wake; a fresh edge is needed.
- R8: A qualifying pin change raises `osc_run` on the third rising edge of `clk_aon` after it, while `cpu_clk_en` stays 0.
- R9: STABILIZE lasts exactly 2^(BASE_LOG2 + STEP_LOG2*sel) cycles. Here sel is `stab_sel` as captured at entry; changes made during standby have no effect.
- R10: On counter overflow, WAKE lasts one cycle with `wake_req`=1, `cpu_clk_en`=1 and `wake_src` (0 = NMI pin, 1 = IRQ pin). The controller then returns to RUN with `wake_req`=0.
- R11: When both pins produce qualifying edges in the same cycle, `wake_src` reports 0 (NMI).
- R12: `sleep_req` during STANDBY or STABILIZE has no effect on the sequence or its timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_aon | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stby_en | input | 1 | Standby-enable bit |
| sleep_req | input | 1 | Sleep request strobe |
| nmi_pin | input | 1 | Non-maskable wake pin (asynchronous) |
| nmi_rise | input | 1 | NMI wake edge: 0 falling, 1 rising |
| irq_pin | input | 1 | Interrupt wake pin (asynchronous) |
| irq_mode | input | 2 | IRQ mode: 00 level, 01 fall, 10 rise, 11 both |
| stab_sel | input | SEL_W | Stabilization period select |
| cpu_clk_en | output | 1 | Chip clock gate enable |
| osc_run | output | 1 | Oscillator run request |
| wake_req | output | 1 | Wake exception request pulse |
| wake_src | output | 1 | Wake source: 0 NMI, 1 IRQ |

## Verification
Standby entry is visible one cycle after the sampled sleep strobe. A pin change driven between clock edges shows up as `osc_run` three edges later: two synchronizer stages plus the state register. `wake_req` follows exactly 2^(BASE_LOG2+STEP_LOG2*sel) edges after that, and returns to 0 one edge later. The bench drives every input on the falling clock edge and steps exactly those counts of rising edges before sampling. It checks the cycle just before each transition as well as the cycle of the transition, so an early or a late change is caught. Cases that must not wake hold for twelve cycles, well past the three-edge detection latency, before `osc_run` is checked.

// File: rtl/swk_pkg.sv
package swk_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STANDBY = 2'd1,
        ST_STAB    = 2'd2,
        ST_WAKE    = 2'd3
    } swk_state_e;

    typedef enum logic [1:0] {
        IRQ_LEVEL = 2'b00,
        IRQ_FALL  = 2'b01,
        IRQ_RISE  = 2'b10,
        IRQ_BOTH  = 2'b11
    } irq_mode_e;

    typedef enum logic {
        SRC_NMI = 1'b0,
        SRC_IRQ = 1'b1
    } wake_src_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_sel_t;

    // Edge that may end standby for each IRQ mode; level mode never wakes,
    // both-edge mode restarts the oscillator on the falling edge.
    function automatic edge_sel_t irq_edge_sel(input irq_mode_e mode);
        edge_sel_t s;
        unique case (mode)
            IRQ_FALL:  s = '{rise: 1'b0, fall: 1'b1};
            IRQ_RISE:  s = '{rise: 1'b1, fall: 1'b0};
            IRQ_BOTH:  s = '{rise: 1'b0, fall: 1'b1};
            default:   s = '{rise: 1'b0, fall: 1'b0};
        endcase
        return s;
    endfunction

    function automatic edge_sel_t nmi_edge_sel(input logic rise_sel);
        return '{rise: rise_sel, fall: !rise_sel};
    endfunction

endpackage

// File: rtl/swk_sync.sv
module swk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/swk_edge_det.sv
module swk_edge_det
    import swk_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  logic      arm,
    input  edge_sel_t sel,
    output logic      hit
);
    logic prev_q;

    // prev follows the synchronized level at all times, so on entry to
    // standby it already holds the pin level: a pin parked at its post-edge
    // level yields no edge until it moves away and back.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        hit = arm && ((sel.rise && !prev_q && lvl) ||
                      (sel.fall && prev_q && !lvl));
    end
endmodule

// File: rtl/swk_stab_timer.sv
module swk_stab_timer #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel_in,
    input  logic             run,
    output logic             done
);
    localparam int MAX_SEL = (1 << SEL_W) - 1;
    localparam int CNT_W   = BASE_LOG2 + STEP_LOG2 * MAX_SEL;

    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    int               shift;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sel_q <= '0;
        else if (load) sel_q <= sel_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (!run) cnt_q <= '0;
        else           cnt_q <= cnt_q + CNT_W'(1);
    end

    // Terminal count 2^shift - 1; at shift == CNT_W the shift wraps to zero
    // and the subtraction yields all ones, which is still the right value.
    always_comb begin
        shift = BASE_LOG2 + STEP_LOG2 * int'(sel_q);
        last  = (CNT_W'(1) << shift) - CNT_W'(1);
        done  = run && (cnt_q == last);
    end
endmodule

// File: rtl/stby_wake_ctrl.sv
module stby_wake_ctrl
    import swk_pkg::*;
#(
    parameter int SEL_W       = 3,
    parameter int BASE_LOG2   = 6,
    parameter int STEP_LOG2   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_aon,
    input  logic             rst_n,
    input  logic             stby_en,
    input  logic             sleep_req,
    input  logic             nmi_pin,
    input  logic             nmi_rise,
    input  logic             irq_pin,
    input  logic [1:0]       irq_mode,
    input  logic [SEL_W-1:0] stab_sel,
    output logic             cpu_clk_en,
    output logic             osc_run,
    output logic             wake_req,
    output logic             wake_src
);
    localparam int NSRC    = 2;
    localparam int IDX_NMI = 0;
    localparam int IDX_IRQ = 1;

    swk_state_e state_q, state_d;

    logic [NSRC-1:0] pin_sync;
    logic [NSRC-1:0] hit;
    edge_sel_t       sel_v [NSRC];

    logic      nmi_rise_q;
    irq_mode_e irq_mode_q;
    wake_src_e src_q;
    logic      enter, armed, stab_done;

    swk_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk_aon),
        .rst_n (rst_n),
        .din   ({irq_pin, nmi_pin}),
        .dout  (pin_sync)
    );

    assign enter = (state_q == ST_RUN) && sleep_req && stby_en;
    assign armed = (state_q == ST_STANDBY);

    // Wake configuration is frozen at the moment of entry.
    always_ff @(posedge clk_aon or negedge rst_n) begin
        if (!rst_n) begin
            nmi_rise_q <= 1'b0;
            irq_mode_q <= IRQ_LEVEL;
        end else if (enter) begin
            nmi_rise_q <= nmi_rise;
            irq_mode_q <= irq_mode_e'(irq_mode);
        end
    end

    always_comb begin
        sel_v[IDX_NMI] = nmi_edge_sel(nmi_rise_q);
        sel_v[IDX_IRQ] = irq_edge_sel(irq_mode_q);
    end

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_det
            swk_edge_det u_det (
                .clk   (clk_aon),
                .rst_n (rst_n),
                .lvl   (pin_sync[g]),
                .arm   (armed),
                .sel   (sel_v[g]),
                .hit   (hit[g])
            );
        end
    endgenerate

    // NMI wins when both detectors fire together.
    always_ff @(posedge clk_aon or negedge rst_n) begin
        if (!rst_n)
            src_q <= SRC_NMI;
        else if (armed && (|hit))
            src_q <= hit[IDX_NMI] ? SRC_NMI : SRC_IRQ;
    end

    swk_stab_timer #(
        .SEL_W     (SEL_W),
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2)
    ) u_timer (
        .clk    (clk_aon),
        .rst_n  (rst_n),
        .load   (enter),
        .sel_in (stab_sel),
        .run    (state_q == ST_STAB),
        .done   (stab_done)
    );

    // State register
    always_ff @(posedge clk_aon or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     if (enter)     state_d = ST_STANDBY;
            ST_STANDBY: if (|hit)      state_d = ST_STAB;
            ST_STAB:    if (stab_done) state_d = ST_WAKE;
            ST_WAKE:                   state_d = ST_RUN;
            default:                   state_d = ST_RUN;
        endcase
    end

    // Output decode
    always_comb begin
        cpu_clk_en = 1'b0;
        osc_run    = 1'b0;
        wake_req   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                osc_run    = 1'b1;
            end
            ST_STANDBY: begin
                cpu_clk_en = 1'b0;
                osc_run    = 1'b0;
            end
            ST_STAB: begin
                osc_run    = 1'b1;
            end
            ST_WAKE: begin
                cpu_clk_en = 1'b1;
                osc_run    = 1'b1;
                wake_req   = 1'b1;
            end
            default: begin
                cpu_clk_en = 1'b1;
                osc_run    = 1'b1;
            end
        endcase
    end

    assign wake_src = src_q;
endmodule

// File: rtl/swk_chk.sv
module swk_chk #(
    parameter int SEL_W     = 3,
    parameter int BASE_LOG2 = 6,
    parameter int STEP_LOG2 = 2
) (
    input logic             clk_aon,
    input logic             rst_n,
    input logic             stby_en,
    input logic             sleep_req,
    input logic [SEL_W-1:0] stab_sel,
    input logic             cpu_clk_en,
    input logic             osc_run,
    input logic             wake_req
);
    logic             in_run;
    logic [SEL_W-1:0] sel_cap;
    logic [31:0]      win_cnt;
    logic [31:0]      win_exp;

    assign in_run  = cpu_clk_en && !wake_req;
    assign win_exp = 32'd1 << (BASE_LOG2 + STEP_LOG2 * int'(sel_cap));

    always_ff @(posedge clk_aon or negedge rst_n) begin
        if (!rst_n)                             sel_cap <= '0;
        else if (in_run && sleep_req && stby_en) sel_cap <= stab_sel;
    end

    always_ff @(posedge clk_aon or negedge rst_n) begin
        if (!rst_n)                      win_cnt <= '0;
        else if (osc_run && !cpu_clk_en) win_cnt <= win_cnt + 32'd1;
        else                             win_cnt <= '0;
    end

    // R2
    enter_stby_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        in_run && sleep_req && stby_en |=> !cpu_clk_en && !osc_run);

    // R3
    no_entry_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        in_run && sleep_req && !stby_en |=> cpu_clk_en);

    // R8
    osc_first_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        $rose(osc_run) |-> !cpu_clk_en);

    // R10
    clk_with_req_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> wake_req && osc_run);

    // R10
    req_pulse_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        wake_req |=> !wake_req && cpu_clk_en);

    // R9
    stab_len_chk: assert property (@(posedge clk_aon) disable iff (!rst_n)
        wake_req |-> win_cnt == win_exp);
endmodule

bind stby_wake_ctrl swk_chk #(
    .SEL_W     (SEL_W),
    .BASE_LOG2 (BASE_LOG2),
    .STEP_LOG2 (STEP_LOG2)
) u_chk (
    .clk_aon    (clk_aon),
    .rst_n      (rst_n),
    .stby_en    (stby_en),
    .sleep_req  (sleep_req),
    .stab_sel   (stab_sel),
    .cpu_clk_en (cpu_clk_en),
    .osc_run    (osc_run),
    .wake_req   (wake_req)
);

// File: tb/stby_wake_ctrl_tb.sv
`timescale 1ns/1ps
module stby_wake_ctrl_tb;
    localparam int BASE = 2;
    localparam int STEP = 1;
    localparam int NV   = 12;

    // {use_irq, nmi_rise, irq_mode[1:0], init_lvl, sel[2:0], exp_wake}
    localparam logic [8:0] VEC [NV] = '{
        9'b0_0_00_1_000_1,  // R4 NMI falling select, falling edge
        9'b0_1_00_0_001_1,  // R4 NMI rising select, rising edge
        9'b0_1_00_1_000_0,  // R4 rising select, falling edge
        9'b0_0_00_0_000_0,  // R4 falling select, rising edge
        9'b1_0_01_1_010_1,  // R5 IRQ falling
        9'b1_0_10_0_000_1,  // R5 IRQ rising
        9'b1_0_11_1_001_1,  // R5 IRQ both, falling edge
        9'b1_0_11_0_000_0,  // R5 IRQ both, rising edge
        9'b1_0_00_1_000_0,  // R6 IRQ level, pin held low
        9'b1_0_10_1_000_0,  // R5 rising mode, falling edge
        9'b1_0_01_0_000_0,  // R5 falling mode, rising edge
        9'b0_0_00_1_011_1   // R9 NMI, longest period in table
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stby_en = 1'b0;
    logic       sleep_req = 1'b0;
    logic       nmi_pin = 1'b1;
    logic       nmi_rise = 1'b0;
    logic       irq_pin = 1'b1;
    logic [1:0] irq_mode = 2'b00;
    logic [2:0] stab_sel = 3'd0;
    logic       cpu_clk_en, osc_run, wake_req, wake_src;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    stby_wake_ctrl #(.SEL_W(3), .BASE_LOG2(BASE), .STEP_LOG2(STEP)) u_dut (
        .clk_aon    (clk),
        .rst_n      (rst_n),
        .stby_en    (stby_en),
        .sleep_req  (sleep_req),
        .nmi_pin    (nmi_pin),
        .nmi_rise   (nmi_rise),
        .irq_pin    (irq_pin),
        .irq_mode   (irq_mode),
        .stab_sel   (stab_sel),
        .cpu_clk_en (cpu_clk_en),
        .osc_run    (osc_run),
        .wake_req   (wake_req),
        .wake_src   (wake_src)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(4);
    endtask

    task automatic enter_stby(input logic [2:0] sel);
        stab_sel  = sel;
        stby_en   = 1'b1;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        check("R2", "clk_en after entry", 32'(cpu_clk_en), 32'd0);
        check("R2", "osc_run after entry", 32'(osc_run), 32'd0);
    endtask

    // Call right after the qualifying pin change, at a falling edge.
    task automatic expect_wake(input int term, input logic src, input string req);
        step(2);
        check("R8", "osc_run before detect", 32'(osc_run), 32'd0);
        step(1);
        check("R8", "osc_run at detect", 32'(osc_run), 32'd1);
        check("R8", "clk_en held at detect", 32'(cpu_clk_en), 32'd0);
        step(term - 1);
        check("R9", "clk_en last stab cycle", 32'(cpu_clk_en), 32'd0);
        step(1);
        check("R10", "wake_req pulse", 32'(wake_req), 32'd1);
        check("R10", "clk_en in wake", 32'(cpu_clk_en), 32'd1);
        check(req, "wake_src", 32'(wake_src), 32'(src));
        step(1);
        check("R10", "wake_req cleared", 32'(wake_req), 32'd0);
        check("R10", "clk_en in run", 32'(cpu_clk_en), 32'd1);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL all watchdog: actual=expired expected=done");
        report();
        $finish;
    end

    initial begin
        @(negedge clk);
        step(1);
        // R1 reset state
        check("R1", "clk_en in reset", 32'(cpu_clk_en), 32'd1);
        check("R1", "osc_run in reset", 32'(osc_run), 32'd1);
        check("R1", "wake_req in reset", 32'(wake_req), 32'd0);
        rst_n = 1'b1;
        step(4);
        check("R1", "clk_en after reset", 32'(cpu_clk_en), 32'd1);

        // R3 sleep without enable
        stby_en   = 1'b0;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        check("R3", "clk_en kept", 32'(cpu_clk_en), 32'd1);
        step(5);
        check("R3", "osc_run kept", 32'(osc_run), 32'd1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic [8:0] v;
            v        = VEC[i];
            nmi_rise = v[7];
            irq_mode = v[6:5];
            nmi_pin  = v[8] ? 1'b1 : v[4];
            irq_pin  = v[8] ? v[4] : 1'b1;
            step(4);
            enter_stby(v[3:1]);
            step(2);
            if (v[8]) irq_pin = ~v[4];
            else      nmi_pin = ~v[4];
            if (v[0]) begin
                expect_wake(1 << (BASE + STEP * int'(v[3:1])), v[8],
                            v[8] ? "R5" : "R4");
            end else begin
                step(12);
                check(v[8] ? "R5" : "R4", "no wake osc_run", 32'(osc_run), 32'd0);
                check(v[8] ? "R6" : "R4", "no wake clk_en", 32'(cpu_clk_en), 32'd0);
                do_reset();
            end
        end

        // R7 pin already at post-edge level on entry
        nmi_rise = 1'b1;
        irq_mode = 2'b00;
        nmi_pin  = 1'b1;
        irq_pin  = 1'b1;
        step(4);
        enter_stby(3'd0);
        step(12);
        check("R7", "parked pin no wake", 32'(osc_run), 32'd0);
        nmi_pin = 1'b0;
        step(4);
        check("R7", "falling leg no wake", 32'(osc_run), 32'd0);
        nmi_pin = 1'b1;
        expect_wake(4, 1'b0, "R7");

        // R9 / R12 select change and sleep strobes while waiting
        nmi_rise = 1'b0;
        nmi_pin  = 1'b1;
        step(4);
        enter_stby(3'd0);
        stab_sel  = 3'd3;
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        check("R12", "sleep in standby", 32'(osc_run), 32'd0);
        nmi_pin = 1'b0;
        step(3);
        check("R8", "osc_run at detect", 32'(osc_run), 32'd1);
        sleep_req = 1'b1;
        step(1);
        sleep_req = 1'b0;
        step(2);
        check("R12", "clk_en still gated", 32'(cpu_clk_en), 32'd0);
        step(1);
        check("R9", "entry select kept", 32'(wake_req), 32'd1);
        check("R12", "wake on time", 32'(cpu_clk_en), 32'd1);
        step(1);

        // R11 simultaneous edges
        nmi_rise = 1'b0;
        irq_mode = 2'b01;
        nmi_pin  = 1'b1;
        irq_pin  = 1'b1;
        step(4);
        enter_stby(3'd0);
        step(2);
        nmi_pin = 1'b0;
        irq_pin = 1'b0;
        expect_wake(4, 1'b0, "R11");

        report();
        $finish;
    end
endmodule